// File: doc/BRIEF.md
# PLL Control Word and Core-Clock Source Sequencer

This block is the digital control side of a clock-multiplier PLL. It holds one control word that carries a 12-bit multiplication factor, a 4-bit division factor, a PLL enable bit and a bit that forces the reference clock. Software writes and reads the word over a small single-cycle register bus. The block drives the loop's ratio and enable controls. It also drives the select input of an external glitch-free clock multiplexer, which chooses between the external reference and the PLL path. The ratio of output to reference is the multiplication factor divided by the division factor. A division factor of zero means the low-power divider is bypassed, and the ratio then uses a divisor of one.

Hardware reset is synchronous to the reference clock, which keeps running while reset is held. While reset is asserted, the enable bit copies the PLL-init pin on every cycle. If the enable bit is set, the clock select waits on the reference until the synchronized lock from the analog loop arrives, and then moves to the PLL path. The lock input passes through a two-flop synchronizer before any logic uses it. The lock status seen by software is qualified so that it reads as not locked while reset is asserted.

The bus has no flow control. A write completes in the cycle it is presented, and read data is combinational from the address, so the interface has no valid/ready handshake and no back-pressure.

Top module: `pll_ctrl_top`

## Requirements
- R1: While reset is held, each clock edge loads the multiplication factor with parameter MF_RST (default 20), clears the division factor and clears the force-reference bit.
- R2: While reset is held, the enable bit takes the value of pll_init_i at every clock edge.
- R3: With the enable bit set during reset, clk_sel_pll_o stays 0 (reference) until the synchronized lock is high, and then becomes 1 (PLL path).
- R4: Whenever the enable bit is 0, clk_sel_pll_o is 0.
- R5: A software write that clears the enable bit makes clk_sel_pll_o 0 after the same clock edge that stores the write.
- R6: Status bit 0 (address 1) and lock_ok_o read 0 while reset is held. After reset is released they show the synchronized lock.
- R7: The lock input passes through two flops. A rise of lock_raw_i sampled at edge k can set clk_sel_pll_o no earlier than edge k+2, so the select is seen high after the third edge.
- R8: div_bypass_o is a registered flag. It is 1 exactly when the stored division factor is 0, and it updates on the same edge as the factor.
- R9: Any write to address 0 forces clk_sel_pll_o to 0 until a new rising edge of the synchronized lock is seen after the write.
- R10: When the force-reference bit (bit 17) is 1, clk_sel_pll_o is 0.
- R11: Address 0 holds the control word: bits 11:0 multiplication factor, bits 15:12 division factor, bit 16 enable, bit 17 force-reference, upper bits read 0. Address 1 holds the status: bit 0 qualified lock, bit 1 select, bit 2 bypass. A write shows on the outputs after one edge, and writes made during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| pll_init_i | input | 1 | PLL-init pin, sampled into the enable bit during reset |
| lock_raw_i | input | 1 | Asynchronous lock from the analog loop |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 1 | Register address (0 control, 1 status) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| mult_o | output | 12 | Multiplication factor to the loop |
| div_o | output | 4 | Division factor to the low-power divider |
| pll_en_o | output | 1 | PLL enable |
| div_bypass_o | output | 1 | Divider bypass, high when the division factor is zero |
| clk_sel_pll_o | output | 1 | Clock mux select: 1 PLL path, 0 reference |
| lock_ok_o | output | 1 | Qualified synchronized lock |

## Verification
The assertions assume that reset is held for at least as many cycles as the synchronizer is deep. They also assume that lock_raw_i stays stable long enough to cross both flops, and that bus_wr_i is only acted on outside reset. The bench changes every input at the falling clock edge. It holds each lock level for at least three edges, and it checks results only at falling edges after the registers have settled. So each property sees clean, fully synchronized values.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int MF_W   = 12;
  localparam int DF_W   = 4;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic            force_ref;
    logic            en;
    logic [DF_W-1:0] df;
    logic [MF_W-1:0] mf;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
endpackage

// File: rtl/pll_ctrl_sync.sv
module pll_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_ctrl_pkg::*;
#(
  parameter logic [MF_W-1:0] MF_RST = 12'd20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_init_i,
  input  logic       wr_ctrl_i,
  input  ctrl_word_t wdata_i,
  output ctrl_word_t ctrl_q_o,
  output ctrl_word_t ctrl_d_o
);
  ctrl_word_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (!rst_n) begin
      ctrl_d.mf        = MF_RST;
      ctrl_d.df        = '0;
      ctrl_d.force_ref = 1'b0;
      ctrl_d.en        = pll_init_i;
    end else if (wr_ctrl_i) begin
      ctrl_d = wdata_i;
    end
  end

  always_ff @(posedge clk) ctrl_q <= ctrl_d;

  assign ctrl_q_o = ctrl_q;
  assign ctrl_d_o = ctrl_d;

  logic in_rst_q;
  always_ff @(posedge clk) in_rst_q <= !rst_n;

  // R1: one edge after a reset cycle the reset values are held
  always @(posedge clk) begin
    if (in_rst_q) begin
      a_r1_reset_values: assert (ctrl_q.mf == MF_RST && ctrl_q.df == '0 && !ctrl_q.force_ref);
    end
  end
endmodule

// File: rtl/pll_ctrl_srcsel.sv
module pll_ctrl_srcsel
  import pll_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_d_i,
  input  logic            force_d_i,
  input  logic [DF_W-1:0] df_d_i,
  input  logic            wr_ctrl_i,
  input  logic            lock_sync_i,
  output logic            sel_pll_o,
  output logic            bypass_o
);
  logic hold_q, hold_d;
  logic lock_prev_q;
  logic lock_rise;
  logic sel_q, byp_q;

  assign lock_rise = lock_sync_i & ~lock_prev_q;

  always_comb begin
    if (!rst_n)         hold_d = 1'b0;
    else if (wr_ctrl_i) hold_d = 1'b1;
    else                hold_d = hold_q & ~lock_rise;
  end

  always_ff @(posedge clk) begin
    lock_prev_q <= lock_sync_i;
    hold_q      <= hold_d;
    sel_q       <= en_d_i & ~force_d_i & ~hold_d & lock_sync_i;
    byp_q       <= (df_d_i == '0);
  end

  assign sel_pll_o = sel_q;
  assign bypass_o  = byp_q;

  // R9: a control write always lands on the reference
  a_r9_write_forces_ref: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_i |=> !sel_q);

  // R3: PLL path only after a synchronized lock
  a_r3_sel_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> $past(lock_sync_i));
endmodule

// File: rtl/pll_ctrl_top.sv
module pll_ctrl_top
  import pll_ctrl_pkg::*;
#(
  parameter logic [11:0] MF_RST      = 12'd20,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pll_init_i,
  input  logic        lock_raw_i,
  input  logic        bus_wr_i,
  input  logic        bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic [11:0] mult_o,
  output logic [3:0]  div_o,
  output logic        pll_en_o,
  output logic        div_bypass_o,
  output logic        clk_sel_pll_o,
  output logic        lock_ok_o
);
  localparam int PAD_W = DATA_W - CTRL_W;

  ctrl_word_t ctrl_q, ctrl_d, wr_word;
  logic       wr_ctrl;
  logic       lock_sync;

  assign wr_ctrl = bus_wr_i & rst_n & (bus_addr_i == 1'b0);
  assign wr_word = ctrl_word_t'(bus_wdata_i[CTRL_W-1:0]);

  pll_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (lock_raw_i),
    .q_o (lock_sync)
  );

  pll_ctrl_regs #(.MF_RST(MF_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_init_i (pll_init_i),
    .wr_ctrl_i  (wr_ctrl),
    .wdata_i    (wr_word),
    .ctrl_q_o   (ctrl_q),
    .ctrl_d_o   (ctrl_d)
  );

  pll_ctrl_srcsel u_srcsel (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_d_i      (ctrl_d.en),
    .force_d_i   (ctrl_d.force_ref),
    .df_d_i      (ctrl_d.df),
    .wr_ctrl_i   (wr_ctrl),
    .lock_sync_i (lock_sync),
    .sel_pll_o   (clk_sel_pll_o),
    .bypass_o    (div_bypass_o)
  );

  assign mult_o    = ctrl_q.mf;
  assign div_o     = ctrl_q.df;
  assign pll_en_o  = ctrl_q.en;
  assign lock_ok_o = lock_sync & rst_n;

  always_comb begin
    if (bus_addr_i == 1'b0) bus_rdata_o = {{PAD_W{1'b0}}, ctrl_q};
    else bus_rdata_o = {29'd0, div_bypass_o, clk_sel_pll_o, lock_ok_o};
  end

  // R6: status lock reads invalid during reset
  always_comb begin
    if (!rst_n) a_r6_status_in_reset: assert (!lock_ok_o);
  end

  // R4: no PLL select without enable
  a_r4_no_enable_no_pll: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en_o |-> !clk_sel_pll_o);

  // R10: force-reference bit keeps the reference
  a_r10_force_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.force_ref |-> !clk_sel_pll_o);

  // R8: bypass flag tracks a zero division factor
  a_r8_bypass_tracks_div: assert property (@(posedge clk) disable iff (!rst_n)
    div_bypass_o == (div_o == 4'd0));
endmodule

// File: tb/pll_ctrl_top_tb.sv
module pll_ctrl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] MF_RST = 12'd20;
  localparam int NVEC = 6;

  // vector: {force, en, df, mf, expected bypass}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 4'h0, 12'h001, 1'b1},
    {1'b0, 1'b1, 4'h1, 12'hFFF, 1'b0},
    {1'b0, 1'b1, 4'hF, 12'h800, 1'b0},
    {1'b0, 1'b1, 4'h0, 12'h555, 1'b1},
    {1'b0, 1'b1, 4'h8, 12'h0AA, 1'b0},
    {1'b0, 1'b1, 4'h3, 12'h123, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n, pll_init, lock_raw, bus_wr, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [11:0] mult;
  logic [3:0]  div;
  logic        pll_en, bypass, sel_pll, lock_ok;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_ctrl_top #(.MF_RST(MF_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .pll_init_i(pll_init), .lock_raw_i(lock_raw),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .mult_o(mult), .div_o(div), .pll_en_o(pll_en),
    .div_bypass_o(bypass), .clk_sel_pll_o(sel_pll), .lock_ok_o(lock_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic addr, input logic [31:0] data);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_status(output logic [31:0] v);
    bus_addr = 1'b1; #1 v = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; pll_init = 1'b1; lock_raw = 1'b0;
    bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    edges(3);
    chk("R1 mult reset", 32'(mult), 32'(MF_RST));
    chk("R1 div reset", 32'(div), 32'd0);
    chk("R2 enable from pin", 32'(pll_en), 32'd1);
    chk("R8 bypass at reset", 32'(bypass), 32'd1);
    chk("R3 ref before lock", 32'(sel_pll), 32'd0);

    lock_raw = 1'b1;
    edges(2);
    chk("R7 not yet after two edges", 32'(sel_pll), 32'd0);
    edges(1);
    chk("R3 PLL after lock in reset", 32'(sel_pll), 32'd1);
    read_status(rd);
    chk("R6 status invalid in reset", rd & 32'h1, 32'd0);
    chk("R6 lock_ok in reset", 32'(lock_ok), 32'd0);

    pll_init = 1'b0;
    edges(1);
    chk("R2 enable follows pin low", 32'(pll_en), 32'd0);
    chk("R4 ref with enable clear", 32'(sel_pll), 32'd0);
    edges(3);
    chk("R4 stays ref", 32'(sel_pll), 32'd0);
    pll_init = 1'b1;
    edges(1);
    chk("R2 enable follows pin high", 32'(pll_en), 32'd1);

    bus_write(1'b0, 32'h0001_3FFF);
    chk("R11 write ignored in reset", 32'(mult), 32'(MF_RST));

    rst_n = 1'b1;
    edges(1);
    read_status(rd);
    chk("R6 status lock after reset", rd & 32'h1, 32'd1);
    chk("R3 PLL kept after reset", 32'(sel_pll), 32'd1);

    for (int v = 0; v < NVEC; v++) begin
      bus_write(1'b0, {13'd0, VEC[v][18:1]});
      chk("R11 mult field", 32'(mult), 32'(VEC[v][12:1]));
      chk("R11 div field", 32'(div), 32'(VEC[v][16:13]));
      chk("R8 bypass flag", 32'(bypass), 32'(VEC[v][0]));
      chk("R9 select forced ref", 32'(sel_pll), 32'd0);
      bus_addr = 1'b0; #1;
      chk("R11 readback", bus_rdata, {13'd0, VEC[v][18:1]});
    end
    edges(4);
    chk("R9 steady lock not fresh", 32'(sel_pll), 32'd0);

    lock_raw = 1'b0; edges(3);
    lock_raw = 1'b1; edges(2);
    chk("R7 fresh lock two edges", 32'(sel_pll), 32'd0);
    edges(1);
    chk("R9 fresh lock releases", 32'(sel_pll), 32'd1);

    bus_write(1'b0, 32'h0003_1014);
    lock_raw = 1'b0; edges(3);
    lock_raw = 1'b1; edges(3);
    chk("R10 force keeps ref", 32'(sel_pll), 32'd0);

    bus_write(1'b0, 32'h0001_1014);
    lock_raw = 1'b0; edges(3);
    lock_raw = 1'b1; edges(3);
    chk("R10 force cleared", 32'(sel_pll), 32'd1);

    bus_write(1'b0, 32'h0000_1014);
    chk("R5 enable clear next cycle", 32'(sel_pll), 32'd0);
    chk("R5 enable output", 32'(pll_en), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule